// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block sits between operand wakeup and the execution units of an out-of-order core. Each instruction that is ready to run is handed to it together with an operation class, an age tag (a sequence number, smaller meaning older) and an opaque payload. The instruction is filed into a small ready pool owned by its class. Each cycle the selector sends the oldest eligible instructions to the issue lanes, choosing oldest-first across all classes.

The selector does not scan every pooled entry to find the oldest. It keeps a short ordered list with one slot per non-empty class, holding that class's current oldest tag, sorted oldest first. The issue lanes walk this list in order and skip any class whose functional unit reports busy. Each skip is recorded in a saturating event counter. After a class's head issues, its slot is re-sorted using the pool's next-oldest tag. A squash with tag S removes every pooled instruction younger than S, and the list is rebuilt in the same cycle.

Top module: `ofs_issue_select`

## Requirements
- R1: An insert is accepted into the pool named by `ins_class` only while that class's `ins_ready` bit is 1. The bit is 0 when the pool already holds DEPTH (default 8) entries or when `squash_valid` is high. An insert offered while the bit is 0 is dropped and never issues.
- R2: Within one class, instructions issue in increasing sequence-number order, with tags compared as plain unsigned values.
- R3: In any cycle, the valid lanes carry class heads in strictly increasing sequence-number order, with the oldest eligible head on lane 0.
- R4: At most ISSUE_W (default 2) instructions issue per cycle, at most one per class. Valid lanes are packed from lane 0 upward.
- R5: When a class head issues, the class moves to the position in the age order given by its new oldest tag. A class whose pool empties leaves the order.
- R6: A class whose `fu_busy` bit is 1 issues nothing in that cycle, and the next class in age order is considered in its place.
- R7: `busy_count` increases by one for each busy class met while walking the age order before all ISSUE_W lanes are filled. A busy class that sits behind a full set of lanes adds nothing. The counter saturates at its maximum value.
- R8: While `squash_valid` is high, no lane is valid and no insert is taken. At the end of that cycle, every pooled entry with a tag greater than `squash_seq` is removed.
- R9: After reset all pools are empty, no lane is valid, every `ins_ready` bit is 1 and `busy_count` is 0.
- R10: An instruction inserted at a clock edge can appear on a lane in the cycle that follows. An instruction shown on a valid lane is removed at the edge that ends that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_class | input | CLS_W | Operation class of the inserted instruction |
| ins_seq | input | SEQ_W | Age tag of the inserted instruction |
| ins_payload | input | PAY_W | Opaque data carried to the issue lane |
| ins_ready | output | CLASSES | Per-class insert acceptance |
| fu_busy | input | CLASSES | Per-class functional unit busy |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries with a larger tag are removed |
| iss_valid | output | ISSUE_W | Lane valid strobes |
| iss_class | output | ISSUE_W x CLS_W | Class on each lane |
| iss_seq | output | ISSUE_W x SEQ_W | Age tag on each lane |
| iss_payload | output | ISSUE_W x PAY_W | Payload on each lane |
| busy_count | output | CNT_W | Saturating count of busy-class skips |

## Verification
On every cycle the assertions check the lane invariants. Lanes are packed and carry strictly increasing tags from distinct classes. No lane names a busy class. A squash cycle is silent on both issue and insert. The skip counter never decreases.

Only the directed scenarios can show the rest. They check that the right instructions come out, in the right cycles, after the age order is repositioned. They also show that entries refused at a full pool never appear, that a squash removes exactly the younger entries, and that skips behind full lanes go uncounted. Each of these needs a history of inserts that a single-cycle property cannot see.

// File: rtl/ofs_sel_pkg.sv
package ofs_sel_pkg;
   localparam int unsigned DEF_CLASSES = 4;
   localparam int unsigned DEF_DEPTH   = 8;
   localparam int unsigned DEF_SEQ_W   = 8;
   localparam int unsigned DEF_ISSUE_W = 2;
   localparam int unsigned DEF_PAY_W   = 16;
   localparam int unsigned DEF_CNT_W   = 16;
endpackage

// File: rtl/ofs_ready_pool.sv
module ofs_ready_pool #(
   parameter int unsigned DEPTH = ofs_sel_pkg::DEF_DEPTH,
   parameter int unsigned SEQ_W = ofs_sel_pkg::DEF_SEQ_W,
   parameter int unsigned PAY_W = ofs_sel_pkg::DEF_PAY_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_en,
   input  logic [SEQ_W-1:0] ins_seq,
   input  logic [PAY_W-1:0] ins_pay,
   input  logic             pop_en,
   input  logic             sq_en,
   input  logic [SEQ_W-1:0] sq_seq,
   output logic             full_o,
   output logic [SEQ_W-1:0] head_seq_o,
   output logic [PAY_W-1:0] head_pay_o,
   output logic             nxt_any_o,
   output logic [SEQ_W-1:0] nxt_head_o
);
   localparam int unsigned IDX_W = $clog2(DEPTH);

   logic [DEPTH-1:0]            vld_q, vld_n;
   logic [DEPTH-1:0][SEQ_W-1:0] seq_q, seq_n;
   logic [DEPTH-1:0][PAY_W-1:0] pay_q;
   logic [IDX_W-1:0]            head_idx, free_idx;
   logic                        head_hit, free_hit, wr_en;

   // current oldest entry and first free slot
   always_comb begin
      head_hit = 1'b0;
      head_idx = '0;
      free_hit = 1'b0;
      free_idx = '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
         if (vld_q[i] && (!head_hit || seq_q[i] < seq_q[head_idx])) begin
            head_hit = 1'b1;
            head_idx = IDX_W'(i);
         end
         if (!vld_q[i] && !free_hit) begin
            free_hit = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   assign full_o     = &vld_q;
   assign head_seq_o = head_hit ? seq_q[head_idx] : '0;
   assign head_pay_o = head_hit ? pay_q[head_idx] : '0;
   assign wr_en      = ins_en && free_hit && !sq_en;

   // next state: squash takes precedence over pop and insert
   always_comb begin
      vld_n = vld_q;
      seq_n = seq_q;
      if (sq_en) begin
         for (int i = 0; i < int'(DEPTH); i++)
            if (vld_q[i] && seq_q[i] > sq_seq) vld_n[i] = 1'b0;
      end else begin
         if (pop_en && head_hit) vld_n[head_idx] = 1'b0;
         if (wr_en) begin
            vld_n[free_idx] = 1'b1;
            seq_n[free_idx] = ins_seq;
         end
      end
   end

   // oldest tag after this edge, feeding the age-order list
   always_comb begin
      nxt_any_o  = 1'b0;
      nxt_head_o = '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
         if (vld_n[i] && (!nxt_any_o || seq_n[i] < nxt_head_o)) begin
            nxt_any_o  = 1'b1;
            nxt_head_o = seq_n[i];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_n;
   end

   always_ff @(posedge clk) begin
      seq_q <= seq_n;
      if (wr_en) pay_q[free_idx] <= ins_pay;
   end
endmodule

// File: rtl/ofs_age_list.sv
module ofs_age_list #(
   parameter int unsigned CLASSES = ofs_sel_pkg::DEF_CLASSES,
   parameter int unsigned SEQ_W   = ofs_sel_pkg::DEF_SEQ_W,
   localparam int unsigned CLS_W  = $clog2(CLASSES),
   localparam int unsigned LEN_W  = $clog2(CLASSES + 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [CLASSES-1:0]                any_i,
   input  logic [CLASSES-1:0][SEQ_W-1:0]     head_i,
   output logic [CLASSES-1:0][CLS_W-1:0]     ord_o,
   output logic [LEN_W-1:0]                  len_o,
   output logic [CLASSES-1:0]                on_list_o
);
   logic [CLASSES-1:0][CLS_W-1:0] ord_n;

   // each listed class lands at the slot equal to the number of older heads
   always_comb begin
      ord_n = '0;
      for (int c = 0; c < int'(CLASSES); c++) begin
         int rank;
         rank = 0;
         for (int k = 0; k < int'(CLASSES); k++) begin
            if (k != c && any_i[k] &&
                (head_i[k] < head_i[c] || (head_i[k] == head_i[c] && k < c)))
               rank++;
         end
         if (any_i[c]) ord_n[rank] = CLS_W'(c);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ord_o     <= '0;
         len_o     <= '0;
         on_list_o <= '0;
      end else begin
         ord_o     <= ord_n;
         len_o     <= LEN_W'($countones(any_i));
         on_list_o <= any_i;
      end
   end
endmodule

// File: rtl/ofs_issue_pick.sv
module ofs_issue_pick #(
   parameter int unsigned CLASSES = ofs_sel_pkg::DEF_CLASSES,
   parameter int unsigned ISSUE_W = ofs_sel_pkg::DEF_ISSUE_W,
   localparam int unsigned CLS_W  = $clog2(CLASSES),
   localparam int unsigned LEN_W  = $clog2(CLASSES + 1)
) (
   input  logic [CLASSES-1:0][CLS_W-1:0] ord_i,
   input  logic [LEN_W-1:0]              len_i,
   input  logic [CLASSES-1:0]            busy_i,
   input  logic                          hold_i,
   output logic [ISSUE_W-1:0]            lane_vld_o,
   output logic [ISSUE_W-1:0][CLS_W-1:0] lane_cls_o,
   output logic [CLASSES-1:0]            take_o,
   output logic [LEN_W-1:0]              skip_o
);
   always_comb begin
      int lane;
      int skip;
      lane       = 0;
      skip       = 0;
      lane_vld_o = '0;
      lane_cls_o = '0;
      take_o     = '0;
      if (!hold_i) begin
         for (int p = 0; p < int'(CLASSES); p++) begin
            if (LEN_W'(p) < len_i && lane < int'(ISSUE_W)) begin
               if (busy_i[ord_i[p]]) begin
                  skip++;
               end else begin
                  lane_vld_o[lane] = 1'b1;
                  lane_cls_o[lane] = ord_i[p];
                  take_o[ord_i[p]] = 1'b1;
                  lane++;
               end
            end
         end
      end
      skip_o = LEN_W'(skip);
   end
endmodule

// File: rtl/ofs_issue_select.sv
module ofs_issue_select #(
   parameter int unsigned CLASSES = ofs_sel_pkg::DEF_CLASSES,
   parameter int unsigned DEPTH   = ofs_sel_pkg::DEF_DEPTH,
   parameter int unsigned SEQ_W   = ofs_sel_pkg::DEF_SEQ_W,
   parameter int unsigned ISSUE_W = ofs_sel_pkg::DEF_ISSUE_W,
   parameter int unsigned PAY_W   = ofs_sel_pkg::DEF_PAY_W,
   parameter int unsigned CNT_W   = ofs_sel_pkg::DEF_CNT_W,
   localparam int unsigned CLS_W  = $clog2(CLASSES),
   localparam int unsigned LEN_W  = $clog2(CLASSES + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ins_valid,
   input  logic [CLS_W-1:0]              ins_class,
   input  logic [SEQ_W-1:0]              ins_seq,
   input  logic [PAY_W-1:0]              ins_payload,
   output logic [CLASSES-1:0]            ins_ready,
   input  logic [CLASSES-1:0]            fu_busy,
   input  logic                          squash_valid,
   input  logic [SEQ_W-1:0]              squash_seq,
   output logic [ISSUE_W-1:0]            iss_valid,
   output logic [ISSUE_W-1:0][CLS_W-1:0] iss_class,
   output logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq,
   output logic [ISSUE_W-1:0][PAY_W-1:0] iss_payload,
   output logic [CNT_W-1:0]              busy_count
);
   if (CLASSES < 2)                        begin : g_chk_cls   $error("CLASSES must be at least 2"); end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_dep $error("DEPTH must be a power of two >= 2"); end
   if (ISSUE_W < 1 || ISSUE_W > CLASSES)   begin : g_chk_iw    $error("ISSUE_W must be in 1..CLASSES"); end
   if (CNT_W < LEN_W)                      begin : g_chk_cnt   $error("CNT_W too narrow"); end

   logic [CLASSES-1:0]            full, nxt_any, take, on_list;
   logic [CLASSES-1:0][SEQ_W-1:0] head_seq, nxt_head;
   logic [CLASSES-1:0][PAY_W-1:0] head_pay;
   logic [CLASSES-1:0][CLS_W-1:0] ord;
   logic [LEN_W-1:0]              len, skip;

   for (genvar c = 0; c < CLASSES; c++) begin : g_pool
      assign ins_ready[c] = !full[c] && !squash_valid;
      ofs_ready_pool #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .PAY_W(PAY_W)) pool_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .ins_en     (ins_valid && ins_class == CLS_W'(c) && ins_ready[c]),
         .ins_seq    (ins_seq),
         .ins_pay    (ins_payload),
         .pop_en     (take[c]),
         .sq_en      (squash_valid),
         .sq_seq     (squash_seq),
         .full_o     (full[c]),
         .head_seq_o (head_seq[c]),
         .head_pay_o (head_pay[c]),
         .nxt_any_o  (nxt_any[c]),
         .nxt_head_o (nxt_head[c])
      );
   end

   ofs_age_list #(.CLASSES(CLASSES), .SEQ_W(SEQ_W)) order_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_i     (nxt_any),
      .head_i    (nxt_head),
      .ord_o     (ord),
      .len_o     (len),
      .on_list_o (on_list)
   );

   ofs_issue_pick #(.CLASSES(CLASSES), .ISSUE_W(ISSUE_W)) pick_i (
      .ord_i      (ord),
      .len_i      (len),
      .busy_i     (fu_busy & on_list),
      .hold_i     (squash_valid),
      .lane_vld_o (iss_valid),
      .lane_cls_o (iss_class),
      .take_o     (take),
      .skip_o     (skip)
   );

   for (genvar l = 0; l < ISSUE_W; l++) begin : g_lane
      assign iss_seq[l]     = iss_valid[l] ? head_seq[iss_class[l]] : '0;
      assign iss_payload[l] = iss_valid[l] ? head_pay[iss_class[l]] : '0;
   end

   logic [CNT_W:0] cnt_sum;
   assign cnt_sum = {1'b0, busy_count} + (CNT_W + 1)'(skip);

   always_ff @(posedge clk) begin
      if (!rst_n)          busy_count <= '0;
      else if (cnt_sum[CNT_W]) busy_count <= '1;
      else                 busy_count <= cnt_sum[CNT_W-1:0];
   end
endmodule

// File: rtl/ofs_issue_select_chk.sv
module ofs_issue_select_chk #(
   parameter int unsigned CLASSES = 4,
   parameter int unsigned ISSUE_W = 2,
   parameter int unsigned SEQ_W   = 8,
   parameter int unsigned PAY_W   = 16,
   parameter int unsigned CNT_W   = 16,
   localparam int unsigned CLS_W  = $clog2(CLASSES)
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [CLASSES-1:0]            ins_ready,
   input logic [CLASSES-1:0]            fu_busy,
   input logic                          squash_valid,
   input logic [ISSUE_W-1:0]            iss_valid,
   input logic [ISSUE_W-1:0][CLS_W-1:0] iss_class,
   input logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq,
   input logic [CNT_W-1:0]              busy_count
);
   for (genvar l = 0; l < ISSUE_W; l++) begin : g_lane
      // R6: a busy class never reaches a lane
      assert_no_busy_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[l] |-> !fu_busy[iss_class[l]]);
      if (l > 0) begin : g_pair
         // R4: lanes are packed from lane 0
         assert_lanes_packed_R4: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[l] |-> iss_valid[l-1]);
         // R3: later lanes carry younger tags (also distinct classes)
         assert_lane_age_R3: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[l] |-> (iss_seq[l-1] < iss_seq[l] && iss_class[l-1] != iss_class[l]));
      end
   end

   // R8: squash cycle neither issues nor accepts
   assert_squash_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |-> (iss_valid == '0 && ins_ready == '0));

   // R7: skip counter only grows or holds
   assert_busy_cnt_mono_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> busy_count >= $past(busy_count));
endmodule

bind ofs_issue_select ofs_issue_select_chk #(
   .CLASSES(CLASSES), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W), .PAY_W(PAY_W), .CNT_W(CNT_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .ins_ready    (ins_ready),
   .fu_busy      (fu_busy),
   .squash_valid (squash_valid),
   .iss_valid    (iss_valid),
   .iss_class    (iss_class),
   .iss_seq      (iss_seq),
   .busy_count   (busy_count)
);

// File: tb/ofs_issue_select_tb.sv
module ofs_issue_select_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CLASSES = 4, SEQ_W = 8, ISSUE_W = 2, PAY_W = 16, CNT_W = 16;
   localparam int CLS_W = 2;

   logic                          clk = 1'b0;
   logic                          rst_n;
   logic                          ins_valid;
   logic [CLS_W-1:0]              ins_class;
   logic [SEQ_W-1:0]              ins_seq;
   logic [PAY_W-1:0]              ins_payload;
   logic [CLASSES-1:0]            ins_ready;
   logic [CLASSES-1:0]            fu_busy;
   logic                          squash_valid;
   logic [SEQ_W-1:0]              squash_seq;
   logic [ISSUE_W-1:0]            iss_valid;
   logic [ISSUE_W-1:0][CLS_W-1:0] iss_class;
   logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq;
   logic [ISSUE_W-1:0][PAY_W-1:0] iss_payload;
   logic [CNT_W-1:0]              busy_count;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ofs_issue_select dut_i (.*);

   function automatic logic [PAY_W-1:0] pay_of(int c, int s);
      return {8'(c + 1), 8'(s)};
   endfunction

   task automatic chk(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // lane l should be idle (v=0) or carry class c, tag s with matching payload
   task automatic lane(string req, int l, int v, int c, int s);
      chk({req, " valid"}, int'(iss_valid[l]), v);
      if (v != 0 && iss_valid[l]) begin
         chk({req, " class"}, int'(iss_class[l]), c);
         chk({req, " seq"}, int'(iss_seq[l]), s);
         chk({req, " payload"}, int'(iss_payload[l]), int'(pay_of(c, s)));
      end
   endtask

   task automatic put(int c, int s);
      @(negedge clk);
      ins_valid   = 1'b1;
      ins_class   = CLS_W'(c);
      ins_seq     = SEQ_W'(s);
      ins_payload = pay_of(c, s);
   endtask

   task automatic idle();
      @(negedge clk);
      ins_valid = 1'b0;
   endtask

   // advance one cycle with the given busy mask and settle
   task automatic step(logic [CLASSES-1:0] busy);
      @(negedge clk);
      ins_valid = 1'b0;
      fu_busy   = busy;
      #1;
   endtask

   task automatic flush();
      @(negedge clk);
      fu_busy      = '1;
      squash_valid = 1'b1;
      squash_seq   = '0;
      @(negedge clk);
      squash_valid = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk("R9 no lane", int'(iss_valid), 0);
      chk("R9 ready", int'(ins_ready), 15);
      chk("R9 count", int'(busy_count), 0);
   endtask

   task automatic t_in_class();
      fu_busy = '1;
      put(0, 30); put(0, 10); put(0, 20); idle();
      #1 chk("R10 held while busy", int'(iss_valid), 0);
      step(4'b1110); lane("R2 first", 0, 1, 0, 10); lane("R2 one lane", 1, 0, 0, 0);
      step(4'b1110); lane("R2 second", 0, 1, 0, 20);
      step(4'b1110); lane("R2 third", 0, 1, 0, 30);
      step(4'b1110); lane("R2 drained", 0, 0, 0, 0);
      fu_busy = '0;
      put(1, 9); idle(); #1;
      lane("R10 next cycle", 0, 1, 1, 9);
      step('0); lane("R10 removed", 0, 0, 0, 0);
      flush();
   endtask

   task automatic t_cross();
      fu_busy = '1;
      put(0, 5); put(0, 50); put(1, 7); put(2, 3); put(3, 40); idle();
      step('0); lane("R3 a0", 0, 1, 2, 3);  lane("R4 a1", 1, 1, 0, 5);
      step('0); lane("R3 b0", 0, 1, 1, 7);  lane("R4 b1", 1, 1, 3, 40);
      step('0); lane("R3 c0", 0, 1, 0, 50); lane("R4 c1", 1, 0, 0, 0);
      step('0); lane("R4 empty", 0, 0, 0, 0);
      flush();
   endtask

   task automatic t_reposition();
      fu_busy = '1;
      put(0, 1); put(0, 4); put(1, 3); put(2, 2); put(3, 5); idle();
      step('0); lane("R5 a0", 0, 1, 0, 1); lane("R5 a1", 1, 1, 2, 2);
      step('0); lane("R5 b0", 0, 1, 1, 3); lane("R5 b1", 1, 1, 0, 4);
      step('0); lane("R5 c0", 0, 1, 3, 5); lane("R5 c1", 1, 0, 0, 0);
      flush();
   endtask

   task automatic t_busy();
      int base;
      fu_busy = '1;
      put(0, 1); put(1, 2); put(2, 9); idle();
      step(4'b0001); base = int'(busy_count);
      lane("R6 skip0", 0, 1, 1, 2); lane("R6 skip1", 1, 1, 2, 9);
      step(4'b0001);
      chk("R7 +1", int'(busy_count), base + 1);
      lane("R6 held", 0, 0, 0, 0);
      step('0);
      chk("R7 +2", int'(busy_count), base + 2);
      lane("R6 released", 0, 1, 0, 1);
      step('0);
      chk("R7 no skip", int'(busy_count), base + 2);
      flush();
      // busy class behind two filled lanes is not counted
      put(0, 1); put(1, 2); put(2, 3); idle();
      step(4'b0100); base = int'(busy_count);
      lane("R7 full0", 0, 1, 0, 1); lane("R7 full1", 1, 1, 1, 2);
      step('1);
      chk("R7 behind lanes", int'(busy_count), base);
      flush();
   endtask

   task automatic t_full();
      fu_busy = '1;
      for (int i = 0; i < 8; i++) put(3, 101 + i);
      idle(); #1;
      chk("R1 full ready", int'(ins_ready[3]), 0);
      chk("R1 other ready", int'(ins_ready[2]), 1);
      put(3, 200); idle();
      for (int i = 0; i < 8; i++) begin
         step(4'b0111);
         lane("R1 drain", 0, 1, 3, 101 + i);
      end
      step(4'b0111); lane("R1 refused absent", 0, 0, 0, 0);
      flush();
   endtask

   task automatic t_squash();
      fu_busy = '1;
      put(0, 10); put(0, 60); put(1, 70); put(2, 20); idle();
      @(negedge clk);
      fu_busy      = '0;
      squash_valid = 1'b1;
      squash_seq   = 8'd20;
      ins_valid    = 1'b1;
      ins_class    = 2'd3;
      ins_seq      = 8'd5;
      ins_payload  = pay_of(3, 5);
      #1;
      chk("R8 no lane", int'(iss_valid), 0);
      chk("R8 no ready", int'(ins_ready), 0);
      @(negedge clk);
      squash_valid = 1'b0;
      ins_valid    = 1'b0;
      #1;
      lane("R8 keep0", 0, 1, 0, 10); lane("R8 keep1", 1, 1, 2, 20);
      step('0); lane("R8 younger gone", 0, 0, 0, 0);
      flush();
   endtask

   initial begin
      rst_n = 1'b0; ins_valid = 1'b0; ins_class = '0; ins_seq = '0; ins_payload = '0;
      fu_busy = '0; squash_valid = 1'b0; squash_seq = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_in_class();
      t_cross();
      t_reposition();
      t_busy();
      t_full();
      t_squash();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule